// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

This block gathers level-sensitive interrupt requests from a set of sources and routes them to several targets (typically processor harts). Each source carries a pending flag and a 2-bit priority. Each target owns an enable mask over the sources, a priority threshold, a claim/complete register and a software interrupt flag. Per target, the block drives one external interrupt line and one software interrupt line.

Software programs the block through a simple synchronous register port. A read of a target's claim register returns the best eligible source and moves it into the claimed state. A write of that source's ID to the same register completes it. Several sources may be claimed at once, and they may be completed in any order. A claimed source stays gated: its input has no effect until it is completed. Clearing the configuration resets priorities, enables, thresholds and software flags, but it leaves the claim state of every source as it was.

Top module: `irq_hub_top`

## Requirements
- R1: After reset, every output is 0. A claim read returns 0. The pending vector reads 0. Source ID 0 is reserved: its input is ignored and it is never returned as a claimed source.
- R2: A high input on source i (1..NUM_SRC-1) that is not claimed sets pending bit i at the next clock edge. The bit stays set after the input falls, until the source is claimed. The pending vector reads at group 5, with bit i = source i.
- R3: Source i is eligible for target t only when three conditions hold: it is pending, bit i of the target's enable mask is set, and its priority is strictly greater than the target's threshold. An equal priority is not enough.
- R4: A claim read for target t returns the ID of the winning eligible source: the highest priority wins, and on a tie the lowest ID wins. It returns 0 when no source is eligible. A nonzero result clears that source's pending bit and marks it claimed at the same edge. A read that returns 0 changes no state.
- R5: While a source is claimed, its input is ignored and its pending bit stays 0.
- R6: Any number of sources may be claimed at once. A write of a claimed ID completes that source, in any order. If the input is still high, pending is set again at the edge after the completion.
- R7: A completion write is ignored in three cases: the value is 0, the value is NUM_SRC or larger, or the source is not claimed. The full data word is compared, so a large value is never reduced to a smaller ID.
- R8: Each external interrupt output is registered. It is high in the cycle after an edge at which the target had an eligible source, and low in the cycle after an edge at which it had none. So it falls one clock after the claim that removed the last eligible source.
- R9: Each target has a software interrupt flag. A write to group 4 sets the flag to wdata bit 0, so writing 1 forces the interrupt and writing 0 acknowledges it. The flag drives that target's software interrupt output from the edge of the write, and it reads back as bit 0.
- R10: Any write to group 6 clears all priorities, enable masks, thresholds and software flags in one edge. Pending bits and claimed state are unchanged.
- R11: The register address is regAddr[7:4] = group and regAddr[3:0] = index. The groups are:
  - 0: source priority (2 bits, index = source 1..NUM_SRC-1)
  - 1: enable mask (index = target)
  - 2: threshold (2 bits, index = target)
  - 3: claim/complete (index = target)
  - 4: software flag (index = target)
  - 5: pending vector
  - 6: clear configuration

  Read data is combinational while regRe is high. An index out of range reads 0 and its writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Level interrupt inputs; bit 0 is unused |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (a claim read has side effects) |
| regAddr | input | 8 | Group in [7:4], index in [3:0] |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid in the same cycle as regRe |
| irqOut | output | NUM_TGT | Registered external interrupt per target |
| swIrqOut | output | NUM_TGT | Software interrupt per target |

## Verification
Read data is combinational, so the scoreboard monitor compares each read on the falling edge inside the read cycle. A claim's side effects count from the rising edge that ends that cycle. A pending bit appears one edge after its input is seen, or one edge after the completion that releases it. For that reason, the bench idles one cycle before it reads the pending vector after a completion. The external interrupt lags the eligibility by one more register, so its checks sample one full cycle after the configuring write or the claim. The software flags follow their write edge directly and are checked right after that edge.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 4;
  localparam int PRIO_W = 2;

  localparam logic [3:0] GRP_PRIO  = 4'd0;
  localparam logic [3:0] GRP_EN    = 4'd1;
  localparam logic [3:0] GRP_THR   = 4'd2;
  localparam logic [3:0] GRP_CLAIM = 4'd3;
  localparam logic [3:0] GRP_SW    = 4'd4;
  localparam logic [3:0] GRP_PEND  = 4'd5;
  localparam logic [3:0] GRP_CLR   = 4'd6;

  typedef enum logic [2:0] {
    RD_NONE, RD_PRIO, RD_EN, RD_THR, RD_CLAIM, RD_SW, RD_PEND
  } rdSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic             prioWe;
    logic             enWe;
    logic             thrWe;
    logic             swWe;
    logic             cfgClr;
    logic             claimRd;
    logic             complWe;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
  } hubStrobe_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 2
) (
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  output hubStrobe_t        stb
);
  logic [3:0]       grp;
  logic [IDX_W-1:0] idx;
  logic             srcOk, tgtOk;

  assign grp   = regAddr[7:4];
  assign idx   = regAddr[IDX_W-1:0];
  assign srcOk = (idx != '0) && (32'(idx) < NUM_SRC);
  assign tgtOk = 32'(idx) < NUM_TGT;

  always_comb begin
    stb         = '0;
    stb.idx     = idx;
    stb.rdSel   = RD_NONE;
    stb.prioWe  = regWe && grp == GRP_PRIO  && srcOk;
    stb.enWe    = regWe && grp == GRP_EN    && tgtOk;
    stb.thrWe   = regWe && grp == GRP_THR   && tgtOk;
    stb.swWe    = regWe && grp == GRP_SW    && tgtOk;
    stb.complWe = regWe && grp == GRP_CLAIM && tgtOk;
    stb.cfgClr  = regWe && grp == GRP_CLR;
    stb.claimRd = regRe && grp == GRP_CLAIM && tgtOk;
    if (regRe) begin
      unique case (grp)
        GRP_PRIO:  stb.rdSel = srcOk ? RD_PRIO  : RD_NONE;
        GRP_EN:    stb.rdSel = tgtOk ? RD_EN    : RD_NONE;
        GRP_THR:   stb.rdSel = tgtOk ? RD_THR   : RD_NONE;
        GRP_CLAIM: stb.rdSel = tgtOk ? RD_CLAIM : RD_NONE;
        GRP_SW:    stb.rdSel = tgtOk ? RD_SW    : RD_NONE;
        GRP_PEND:  stb.rdSel = RD_PEND;
        default:   stb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_hub_core.sv
module irq_hub_core
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 2,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  hubStrobe_t         stb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_TGT-1:0] irqOut,
  output logic [NUM_TGT-1:0] swIrqOut
);
  localparam int ID_W  = $clog2(NUM_SRC);
  localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  logic [PRIO_W-1:0]  prioQ [NUM_SRC];
  logic [NUM_SRC-1:0] enQ   [NUM_TGT];
  logic [PRIO_W-1:0]  thrQ  [NUM_TGT];
  logic [NUM_SRC-1:0] pendQ, claimedQ, pendNext, claimedNext;
  logic [NUM_SRC-1:0] claimMask, complMask;
  logic [NUM_TGT-1:0] swQ, irqQ, anyElig;
  logic [NUM_TGT-1:0][ID_W-1:0] winId;

  logic [TGT_W-1:0] tgt;
  logic [ID_W-1:0]  srcIdx, claimId, complId;
  logic             complHit;

  assign tgt    = stb.idx[TGT_W-1:0];
  assign srcIdx = stb.idx[ID_W-1:0];

  // Per-target arbitration: highest priority, lowest ID on a tie
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic [NUM_SRC-1:0] elig;
    logic [ID_W-1:0]    win;
    always_comb begin
      logic [PRIO_W-1:0] bestP;
      bestP   = '0;
      win     = '0;
      elig[0] = 1'b0;
      for (int i = NUM_SRC - 1; i >= 1; i--) begin
        elig[i] = pendQ[i] && enQ[t][i] && (prioQ[i] > thrQ[t]);
        if (elig[i] && prioQ[i] >= bestP) begin
          bestP = prioQ[i];
          win   = ID_W'(i);
        end
      end
    end
    assign winId[t]   = win;
    assign anyElig[t] = |elig;
  end

  assign claimId  = winId[tgt];
  assign complId  = wdata[ID_W-1:0];
  assign complHit = stb.complWe && (wdata != '0) &&
                    (wdata < DATA_W'(NUM_SRC)) && claimedQ[complId];

  always_comb begin
    claimMask = '0;
    complMask = '0;
    if (stb.claimRd && claimId != '0) claimMask[claimId] = 1'b1;
    if (complHit) complMask[complId] = 1'b1;
    pendNext    = (pendQ | (srcIn & ~claimedQ & ~NUM_SRC'(1))) & ~claimMask;
    claimedNext = (claimedQ | claimMask) & ~complMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      claimedQ <= '0;
      irqQ     <= '0;
    end else begin
      pendQ    <= pendNext;
      claimedQ <= claimedNext;
      irqQ     <= anyElig;
    end
  end

  // Configuration state, cleared as a group
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) prioQ[i] <= '0;
      for (int t = 0; t < NUM_TGT; t++) begin
        enQ[t]  <= '0;
        thrQ[t] <= '0;
      end
      swQ <= '0;
    end else if (stb.cfgClr) begin
      for (int i = 0; i < NUM_SRC; i++) prioQ[i] <= '0;
      for (int t = 0; t < NUM_TGT; t++) begin
        enQ[t]  <= '0;
        thrQ[t] <= '0;
      end
      swQ <= '0;
    end else begin
      if (stb.prioWe) prioQ[srcIdx] <= wdata[PRIO_W-1:0];
      if (stb.enWe)   enQ[tgt]      <= wdata[NUM_SRC-1:0];
      if (stb.thrWe)  thrQ[tgt]     <= wdata[PRIO_W-1:0];
      if (stb.swWe)   swQ[tgt]      <= wdata[0];
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_PRIO:  rdata = DATA_W'(prioQ[srcIdx]);
      RD_EN:    rdata = DATA_W'(enQ[tgt]);
      RD_THR:   rdata = DATA_W'(thrQ[tgt]);
      RD_CLAIM: rdata = DATA_W'(claimId);
      RD_SW:    rdata = DATA_W'(swQ[tgt]);
      RD_PEND:  rdata = DATA_W'(pendQ);
      default:  rdata = '0;
    endcase
  end

  assign irqOut   = irqQ;
  assign swIrqOut = swQ;
endmodule

// File: rtl/irq_hub_top.sv
module irq_hub_top
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 2,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [NUM_TGT-1:0] irqOut,
  output logic [NUM_TGT-1:0] swIrqOut
);
  hubStrobe_t stb;

  irq_hub_ctrl #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT)) u_ctrl (
    .regWe  (regWe),
    .regRe  (regRe),
    .regAddr(regAddr),
    .stb    (stb)
  );

  irq_hub_core #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .stb     (stb),
    .wdata   (regWdata),
    .rdata   (regRdata),
    .irqOut  (irqOut),
    .swIrqOut(swIrqOut)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 2,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               regWe,
  input logic               regRe,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic [DATA_W-1:0]  regRdata,
  input logic [NUM_TGT-1:0] irqOut,
  input logic [NUM_TGT-1:0] swIrqOut
);
  localparam int ID_W = $clog2(NUM_SRC);

  logic               claimRd, complWr, clrWr;
  logic [NUM_SRC-1:0] shadowQ;
  logic [ID_W-1:0]    rdId;

  assign claimRd = regRe && regAddr[7:4] == GRP_CLAIM && 32'(regAddr[3:0]) < NUM_TGT;
  assign complWr = regWe && regAddr[7:4] == GRP_CLAIM && 32'(regAddr[3:0]) < NUM_TGT &&
                   regWdata != '0 && regWdata < DATA_W'(NUM_SRC);
  assign clrWr   = regWe && regAddr[7:4] == GRP_CLR;
  assign rdId    = regRdata[ID_W-1:0];

  // Port-level record of which IDs are held by software
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowQ <= '0;
    else begin
      if (claimRd && regRdata != '0) shadowQ[rdId] <= 1'b1;
      if (complWr) shadowQ[regWdata[ID_W-1:0]] <= 1'b0;
    end
  end

  assert_claim_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    claimRd |-> regRdata < DATA_W'(NUM_SRC));

  assert_no_double_claim_R5: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd && regRdata != '0) |-> !shadowQ[rdId]);

  assert_clear_drops_sw_R10: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> swIrqOut == '0);

  assert_irq_quiet_after_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |-> ##2 irqOut == '0);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_sw
    assert_sw_follows_write_R9: assert property (@(posedge clk) disable iff (!rstN)
      (regWe && regAddr == {GRP_SW, 4'(t)}) |=> swIrqOut[t] == $past(regWdata[0]));
  end

  logic unusedSrc;
  assign unusedSrc = ^srcIn;
endmodule

bind irq_hub_top irq_hub_chk #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWe(regWe), .regRe(regRe),
  .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
  .irqOut(irqOut), .swIrqOut(swIrqOut)
);

// File: tb/irq_hub_top_bench.sv
`timescale 1ns/1ps
module irq_hub_top_bench;
  localparam int NUM_SRC = 8;
  localparam int NUM_TGT = 2;
  localparam int DATA_W  = 32;
  localparam logic [3:0] G_PRIO = 0, G_EN = 1, G_THR = 2, G_CLAIM = 3,
                         G_SW = 4, G_PEND = 5, G_CLR = 6;

  logic               clk = 1'b0;
  logic               rstN;
  logic [NUM_SRC-1:0] srcIn;
  logic               regWe, regRe;
  logic [7:0]         regAddr;
  logic [DATA_W-1:0]  regWdata, regRdata;
  logic [NUM_TGT-1:0] irqOut, swIrqOut;

  int  nVec = 0;
  int  nBad = 0;
  bit  done = 0;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  irq_hub_top #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .DATA_W(DATA_W)) u_irq_hub_top (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqOut(irqOut), .swIrqOut(swIrqOut)
  );

  // Monitor: compares read data mid-cycle against the queued expectation
  always @(negedge clk) begin
    if (rstN && regRe) begin
      if (sbQ.size() == 0) begin
        nVec++; nBad++;
        $display("FAIL read with no expectation: act=%h", regRdata);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        nVec++;
        if (regRdata !== it.exp) begin
          nBad++;
          $display("FAIL %s: act=%h exp=%h", it.tag, regRdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] g, input logic [3:0] i, input logic [DATA_W-1:0] d);
    regAddr = {g, i}; regWdata = d; regWe = 1'b1;
    @(posedge clk); #1 regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] g, input logic [3:0] i, input logic [DATA_W-1:0] e,
                    input string tag);
    expItem_t it;
    it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    regAddr = {g, i}; regRe = 1'b1;
    @(posedge clk); #1 regRe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [NUM_TGT-1:0] act, input logic [NUM_TGT-1:0] e);
    nVec++;
    if (act !== e) begin
      nBad++;
      $display("FAIL %s: act=%b exp=%b", tag, act, e);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; srcIn = '0; regWe = 1'b0; regRe = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq after reset", irqOut, 2'b00);
    chk("R1 sw after reset", swIrqOut, 2'b00);
    rd(G_PEND, 0, 0, "R1 pending after reset");
    rd(G_CLAIM, 0, 0, "R1 claim after reset");

    // Tie on priority, nesting, drop timing
    srcIn = 8'b0010_1000;
    wr(G_PRIO, 3, 2); wr(G_PRIO, 5, 2); wr(G_EN, 0, 32'h28); wr(G_THR, 0, 1);
    idle(1);
    chk("R3 only enabled target raised", irqOut, 2'b01);
    rd(G_CLAIM, 0, 3, "R4 tie goes to lowest id");
    chk("R8 irq held while 5 eligible", irqOut, 2'b01);
    rd(G_CLAIM, 0, 5, "R6 second claim outstanding");
    chk("R8 irq registered one cycle", irqOut, 2'b01);
    rd(G_CLAIM, 0, 0, "R4 none eligible returns 0");
    chk("R8 irq drops after last claim", irqOut, 2'b00);
    rd(G_PEND, 0, 0, "R5 claimed inputs ignored");

    // Out-of-order completion and re-pend
    wr(G_CLAIM, 0, 5);
    idle(1);
    rd(G_PEND, 0, 32'h20, "R6 completed source re-pends");
    rd(G_CLAIM, 0, 5, "R6 reclaim after out-of-order complete");

    // Ignored completions
    wr(G_CLAIM, 0, 11); wr(G_CLAIM, 0, 0); wr(G_CLAIM, 0, 32'h103);
    idle(1);
    rd(G_PEND, 0, 0, "R7 bad ids ignored, 3 still claimed");

    srcIn = '0;
    wr(G_CLAIM, 0, 3); wr(G_CLAIM, 0, 5);
    idle(1);
    rd(G_PEND, 0, 0, "R2 no re-pend with input low");

    // Priority order and per-target masks, latched pulse
    wr(G_PRIO, 2, 1); wr(G_PRIO, 6, 3); wr(G_EN, 0, 32'h44); wr(G_EN, 1, 32'h04); wr(G_THR, 0, 0);
    srcIn = 8'b0100_0100;
    idle(1);
    srcIn = '0;
    idle(1);
    rd(G_PEND, 0, 32'h44, "R2 pulse latched");
    chk("R3 both targets raised", irqOut, 2'b11);
    rd(G_CLAIM, 0, 6, "R4 higher priority wins");
    rd(G_CLAIM, 1, 2, "R3 target1 mask selects 2");
    wr(G_CLAIM, 1, 2); wr(G_CLAIM, 0, 6);

    // Strict threshold
    srcIn = 8'h40;
    idle(1);
    srcIn = '0;
    wr(G_THR, 0, 3);
    idle(1);
    chk("R3 equal threshold blocks", irqOut, 2'b00);
    rd(G_CLAIM, 0, 0, "R3 equal threshold no claim");
    rd(G_PEND, 0, 32'h40, "R4 empty claim changes nothing");
    wr(G_THR, 0, 2);
    idle(1);
    chk("R3 threshold below priority", irqOut, 2'b01);
    rd(G_CLAIM, 0, 6, "R4 claim after threshold lowered");

    // Software interrupts
    wr(G_SW, 1, 1);
    chk("R9 sw set", swIrqOut, 2'b10);
    rd(G_SW, 1, 1, "R9 sw readback");
    wr(G_SW, 1, 0);
    chk("R9 sw acknowledged", swIrqOut, 2'b00);
    wr(G_SW, 0, 1);

    // Clear config keeps claim state (6 is claimed)
    srcIn = 8'h40;
    wr(G_CLR, 0, 0);
    chk("R10 clear drops sw", swIrqOut, 2'b00);
    rd(G_PRIO, 6, 0, "R10 priority cleared");
    rd(G_EN, 0, 0, "R10 enable cleared");
    rd(G_THR, 0, 0, "R10 threshold cleared");
    rd(G_PEND, 0, 0, "R10 claim survives clear");
    wr(G_CLAIM, 0, 6);
    idle(1);
    rd(G_PEND, 0, 32'h40, "R10 complete after clear");
    srcIn = '0;
    rd(8'hF, 0, 0, "R11 unused group reads 0");
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule